// File: doc/BRIEF.md
# Performance Counter CSR Unit

This unit keeps the performance monitoring state of a small microcontroller core and exposes it through a plain CSR port. The port has a 12-bit address, 32-bit write data, a write enable and 32-bit read data.

The unit holds the following state:
- a free-running 64-bit cycle counter;
- a 64-bit count of retired instructions;
- an inhibit register that can freeze any counter;
- ten event counters, numbered 3 to 12.

Each event counter is tied to one fixed event. Each one also has a selector register that switches it on or off. The 64-bit counters are read and written as two 32-bit halves. Read-only user-level aliases mirror the cycle and retired-instruction counters.

The pipeline, load/store unit, fetch unit, sleep logic and divider each send single-cycle pulses. Reads are combinational: the read data follows the address within the same cycle. A write, or a counted pulse, changes the state at the next rising clock edge. A parameter can remove the ten event counters completely. A second parameter sets their width, from 1 to 32 bits.

Top module: `perf_csr_unit`

## Requirements
- R1: After reset, the following read as zero: the cycle counter (0xB00 low, 0xB80 high), the retired-instruction counter (0xB02, 0xB82), every event counter (0xB03..0xB0C) and the inhibit register (0x320). Selector N (0x323..0x32C, N = 3..12) reads 1<<N.
- R2: The cycle counter increases by one on every clock edge while inhibit bit 0 is clear, and holds while that bit is set. A carry out of the low half increments the high half on the same edge.
- R3: The retired-instruction counter increases by one on each edge where `retire_i` is high and inhibit bit 2 is clear. It holds otherwise.
- R4: A CSR write to any counter half loads that half at the next edge, overriding that cycle's increment. The other half still counts, taking the carry from the old low half.
- R5: Inhibit bits 0, 2 and 3..12 are writable. Bit 1 and bits 13..31 read zero, so writing all ones reads back 0x1FFD.
- R6: Event counter N (address 0xB00+N) increments on each edge where `evt_i[N-3]` is high, selector N is enabled and inhibit bit N is clear. It wraps from all ones to zero. `evt_i` bits 0..9 are: LSU busy, fetch, load, store, jump, conditional branch, taken branch, compressed retire, wait-for-interrupt and divider wait.
- R7: Each selector stores only its bit N. All its other bits read zero. When the bit is zero, the counter holds.
- R8: The high halves of the event counters (0xB83..0xB8C) read zero. Writes to them change nothing.
- R9: 0xC00/0xC80 read the same as 0xB00/0xB80, and 0xC02/0xC82 read the same as 0xB02/0xB82. Writes to these four aliases change nothing.
- R10: With EVT_EN = 0, event counter and selector addresses read zero and inhibit bits 3..12 read zero (all ones reads back 0x5).
- R11: Addresses not mapped above read zero. This includes 0xB01, 0x321, 0xB8D, 0x32D and 0x7C0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_we | input | 1 | CSR write enable, one write per cycle |
| csr_rdata | output | 32 | CSR read data for the current address (combinational) |
| retire_i | input | 1 | Instruction retired this cycle |
| evt_i | input | 10 | Event pulses for counters 3..12 (bit k feeds counter k+3) |

## Verification
Read data is due in the same cycle as its address. A write, an inhibit change or a counted pulse appears in the read data only after the next rising edge. A new inhibit value takes effect on the edge after it is written. The bench therefore drives the address, data and pulses just after a falling edge, and samples the read data 1 ns later. Each expected counter value is the number of rising edges that have passed since the last write, counted under the inhibit and selector state of each cycle. All reads used in a cycle-exact comparison fit inside one low clock phase.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int NUM_EVT   = 10;
  localparam int FIRST_EVT = 3;
  localparam int LAST_EVT  = FIRST_EVT + NUM_EVT - 1;
  localparam int HALF_W    = 32;

  localparam logic [11:0] A_INHIBIT = 12'h320;
  localparam logic [11:0] A_CYC_LO  = 12'hB00;
  localparam logic [11:0] A_CYC_HI  = 12'hB80;
  localparam logic [11:0] A_RET_LO  = 12'hB02;
  localparam logic [11:0] A_RET_HI  = 12'hB82;
  localparam logic [11:0] A_UCYC_LO = 12'hC00;
  localparam logic [11:0] A_UCYC_HI = 12'hC80;
  localparam logic [11:0] A_URET_LO = 12'hC02;
  localparam logic [11:0] A_URET_HI = 12'hC82;

  localparam logic [7:0] PAGE_EVT_LO = 8'hB0;
  localparam logic [7:0] PAGE_EVT_HI = 8'hB8;
  localparam logic [7:0] PAGE_SEL    = 8'h32;

  // bit position within evt_i for each hardwired event
  typedef enum logic [3:0] {
    EV_LSU_BUSY  = 4'd0,
    EV_FETCH     = 4'd1,
    EV_LOAD      = 4'd2,
    EV_STORE     = 4'd3,
    EV_JUMP      = 4'd4,
    EV_BRANCH    = 4'd5,
    EV_BR_TAKEN  = 4'd6,
    EV_RET_COMP  = 4'd7,
    EV_WFI_WAIT  = 4'd8,
    EV_DIV_WAIT  = 4'd9
  } evt_pos_e;
endpackage

// File: rtl/perf_rst_sync.sv
module perf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/perf_wide_counter.sv
module perf_wide_counter #(
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_en,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wdata,
  output logic [2*HW-1:0] value
);
  localparam int FW = 2 * HW;

  logic [FW-1:0] cnt_q, cnt_d;
  logic          cnt_upd;

  always_comb begin
    cnt_d = cnt_q + {{(FW-1){1'b0}}, count_en};
    if (wr_lo) cnt_d[HW-1:0]  = wdata;
    if (wr_hi) cnt_d[FW-1:HW] = wdata;
    cnt_upd = count_en | wr_lo | wr_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_d;
  end

  assign value = cnt_q;
endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_upd;

  always_comb begin
    cnt_d   = wr ? wdata : (cnt_q + {{(W-1){1'b0}}, 1'b1});
    cnt_upd = wr | count_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_d;
  end

  assign value = cnt_q;
endmodule

// File: rtl/perf_csr_unit.sv
module perf_csr_unit
  import perf_pkg::*;
#(
  parameter bit EVT_EN = 1'b1,
  parameter int EVT_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        csr_addr,
  input  logic [31:0]        csr_wdata,
  input  logic               csr_we,
  output logic [31:0]        csr_rdata,
  input  logic               retire_i,
  input  logic [NUM_EVT-1:0] evt_i
);
  localparam int IW = LAST_EVT + 1;
  localparam logic [IW-1:0] EVT_BITS =
    {{(IW-NUM_EVT){1'b0}}, {NUM_EVT{1'b1}}} << FIRST_EVT;
  localparam logic [IW-1:0] BASE_BITS = {{(IW-3){1'b0}}, 3'b101};
  localparam logic [IW-1:0] INH_MASK  = EVT_EN ? (EVT_BITS | BASE_BITS) : BASE_BITS;

  logic rst_n_s;
  perf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  // address decode
  logic [7:0] page;
  logic [3:0] idx;
  logic       idx_evt;
  logic [3:0] slot;
  logic       wr_inh, cyc_wr_lo, cyc_wr_hi, ret_wr_lo, ret_wr_hi;
  logic [NUM_EVT-1:0] evt_wr, sel_wr;

  always_comb begin
    page      = csr_addr[11:4];
    idx       = csr_addr[3:0];
    idx_evt   = (idx >= 4'(FIRST_EVT)) && (idx <= 4'(LAST_EVT));
    slot      = idx - 4'(FIRST_EVT);
    wr_inh    = csr_we && (csr_addr == A_INHIBIT);
    cyc_wr_lo = csr_we && (csr_addr == A_CYC_LO);
    cyc_wr_hi = csr_we && (csr_addr == A_CYC_HI);
    ret_wr_lo = csr_we && (csr_addr == A_RET_LO);
    ret_wr_hi = csr_we && (csr_addr == A_RET_HI);
    for (int k = 0; k < NUM_EVT; k++) begin
      evt_wr[k] = csr_we && (page == PAGE_EVT_LO) && (idx == 4'(k + FIRST_EVT));
      sel_wr[k] = csr_we && (page == PAGE_SEL)    && (idx == 4'(k + FIRST_EVT));
    end
  end

  // inhibit register
  logic [IW-1:0] inh_q, inh_d;

  always_comb inh_d = csr_wdata[IW-1:0] & INH_MASK;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    inh_q <= '0;
    else if (wr_inh) inh_q <= inh_d;
  end

  // fixed 64-bit counters
  logic [2*HALF_W-1:0] cyc_val, ret_val;

  perf_wide_counter #(.HW(HALF_W)) u_cyc (
    .clk(clk), .rst_n(rst_n_s), .count_en(!inh_q[0]),
    .wr_lo(cyc_wr_lo), .wr_hi(cyc_wr_hi), .wdata(csr_wdata), .value(cyc_val)
  );

  perf_wide_counter #(.HW(HALF_W)) u_ret (
    .clk(clk), .rst_n(rst_n_s), .count_en(retire_i && !inh_q[2]),
    .wr_lo(ret_wr_lo), .wr_hi(ret_wr_hi), .wdata(csr_wdata), .value(ret_val)
  );

  // hardwired event counters
  logic [NUM_EVT-1:0][31:0] evt_lo_rd;
  logic [NUM_EVT-1:0][31:0] sel_rd;
  logic [NUM_EVT-1:0]       evt_cnt_en;

  if (EVT_EN) begin : g_evt
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_cnt
      localparam int N = k + FIRST_EVT;
      logic             sel_q;
      logic [EVT_W-1:0] val;

      always_ff @(posedge clk or negedge rst_n_s) begin
        if (!rst_n_s)       sel_q <= 1'b1;
        else if (sel_wr[k]) sel_q <= csr_wdata[N];
      end

      assign evt_cnt_en[k] = evt_i[k] && sel_q && !inh_q[N];

      perf_event_counter #(.W(EVT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n_s), .count_en(evt_cnt_en[k]),
        .wr(evt_wr[k]), .wdata(csr_wdata[EVT_W-1:0]), .value(val)
      );

      assign evt_lo_rd[k] = 32'(val);
      assign sel_rd[k]    = sel_q ? (32'd1 << N) : 32'd0;
    end
  end else begin : g_no_evt
    assign evt_lo_rd  = '0;
    assign sel_rd     = '0;
    assign evt_cnt_en = '0;
  end

  // read mux
  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_INHIBIT:            csr_rdata = 32'(inh_q);
      A_CYC_LO, A_UCYC_LO:  csr_rdata = cyc_val[HALF_W-1:0];
      A_CYC_HI, A_UCYC_HI:  csr_rdata = cyc_val[2*HALF_W-1:HALF_W];
      A_RET_LO, A_URET_LO:  csr_rdata = ret_val[HALF_W-1:0];
      A_RET_HI, A_URET_HI:  csr_rdata = ret_val[2*HALF_W-1:HALF_W];
      default: begin
        if (idx_evt && page == PAGE_EVT_LO)   csr_rdata = evt_lo_rd[slot];
        else if (idx_evt && page == PAGE_SEL) csr_rdata = sel_rd[slot];
      end
    endcase
  end
endmodule

// File: rtl/perf_csr_chk.sv
module perf_csr_chk #(
  parameter int NE = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           csr_we,
  input logic [11:0]    csr_addr,
  input logic [31:0]    csr_wdata,
  input logic [31:0]    csr_rdata,
  input logic [12:0]    inh_q,
  input logic [63:0]    cyc_val,
  input logic [63:0]    ret_val,
  input logic           retire_i,
  input logic           cyc_wr_lo,
  input logic           cyc_wr_hi,
  input logic           ret_wr_lo,
  input logic           ret_wr_hi,
  input logic [NE-1:0]  evt_cnt_en,
  input logic [NE-1:0]  evt_wr,
  input logic [NE-1:0][31:0] evt_lo_rd
);
  // R2: free-running step and hold
  assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inh_q[0] && !cyc_wr_lo && !cyc_wr_hi) |=> (cyc_val == $past(cyc_val) + 64'd1));
  assert_cycle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q[0] && !cyc_wr_lo && !cyc_wr_hi) |=> $stable(cyc_val));

  // R3: retired-instruction counting
  assert_ret_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !inh_q[2] && !ret_wr_lo && !ret_wr_hi) |=> (ret_val == $past(ret_val) + 64'd1));
  assert_ret_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(retire_i && !inh_q[2]) && !ret_wr_lo && !ret_wr_hi) |=> $stable(ret_val));

  // R4: write beats increment
  assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'hB00) |=> (cyc_val[31:0] == $past(csr_wdata)));

  // R9: alias reads mirror the machine counter
  assert_alias_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'hC80) |-> (csr_rdata == cyc_val[63:32]));

  // R8: event high halves read zero
  assert_evt_hi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr[11:4] == 8'hB8 && csr_addr[3:0] >= 4'd3 && csr_addr[3:0] <= 4'd12)
    |-> (csr_rdata == 32'd0));

  // R6/R7: an event counter without enable or write holds
  for (genvar k = 0; k < NE; k++) begin : g_hold
    assert_evt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_cnt_en[k] && !evt_wr[k]) |=> $stable(evt_lo_rd[k]));
  end
endmodule

bind perf_csr_unit perf_csr_chk #(.NE(perf_pkg::NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .csr_we(csr_we), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .inh_q(inh_q),
  .cyc_val(cyc_val), .ret_val(ret_val), .retire_i(retire_i),
  .cyc_wr_lo(cyc_wr_lo), .cyc_wr_hi(cyc_wr_hi),
  .ret_wr_lo(ret_wr_lo), .ret_wr_hi(ret_wr_hi),
  .evt_cnt_en(evt_cnt_en), .evt_wr(evt_wr), .evt_lo_rd(evt_lo_rd)
);

// File: tb/sim_perf_csr_unit.sv
module sim_perf_csr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 10;

  logic        clk;
  logic        rst_n;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata;
  logic        csr_we;
  logic [31:0] csr_rdata;
  logic [31:0] csr_rdata1;
  logic        retire_i;
  logic [NE-1:0] evt_i;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  perf_csr_unit u0 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .retire_i(retire_i), .evt_i(evt_i)
  );

  perf_csr_unit #(.EVT_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata1), .retire_i(retire_i), .evt_i(evt_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic rd1(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr  = a;
    csr_wdata = d;
    csr_we    = 1'b1;
    @(negedge clk);
    csr_we    = 1'b0;
  endtask

  function automatic logic [NE-1:0] pat(input int c, input int seed);
    return NE'((c * 7919) ^ (c >> 2) ^ (c * c * seed) ^ seed);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, a;
    int exp_cnt [NE];
    logic [NE-1:0] en;

    rst_n = 1'b0; csr_addr = '0; csr_wdata = '0; csr_we = 1'b0;
    retire_i = 1'b0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12'h320, d); check("R1 inhibit", d, 32'd0);
    rd(12'hB02, d); check("R1 ret lo", d, 32'd0);
    rd(12'hB82, d); check("R1 ret hi", d, 32'd0);
    rd(12'hB80, d); check("R1 cyc hi", d, 32'd0);
    for (int k = 0; k < NE; k++) begin
      rd(12'hB03 + 12'(k), d); check("R1 event counter", d, 32'd0);
      rd(12'h323 + 12'(k), d); check("R1 selector", d, 32'd1 << (k + 3));
    end

    // R2 free running
    @(negedge clk);
    rd(12'hB00, a);
    repeat (5) @(negedge clk);
    rd(12'hB00, d); check("R2 cycle step", d, a + 32'd5);

    // R5 / R10 inhibit mask
    wr(12'h320, 32'hFFFF_FFFF);
    rd(12'h320, d);  check("R5 inhibit mask", d, 32'h0000_1FFD);
    rd1(12'h320, d); check("R10 inhibit mask no events", d, 32'h0000_0005);

    // R2/R4 exact carry with write priority while running
    wr(12'h320, 32'd0);
    wr(12'hB80, 32'd5);
    wr(12'hB00, 32'hFFFF_FFFE);
    rd(12'hB00, d);  check("R4 write wins lo", d, 32'hFFFF_FFFE);
    rd(12'hB80, d2); check("R4 write hi", d2, 32'd5);
    @(negedge clk);
    rd(12'hB00, d); check("R2 step lo", d, 32'hFFFF_FFFF);
    rd(12'hB80, d); check("R2 before carry", d, 32'd5);
    @(negedge clk);
    rd(12'hB00, d); check("R2 wrap lo", d, 32'd0);
    rd(12'hB80, d); check("R2 carry hi", d, 32'd6);

    // R2 inhibit holds
    wr(12'h320, 32'd1);
    rd(12'hB00, a);
    repeat (4) @(negedge clk);
    rd(12'hB00, d); check("R2 inhibit hold", d, a);
    rd(12'hB80, d); check("R2 inhibit hold hi", d, 32'd6);

    // R3 retired instructions
    @(negedge clk); retire_i = 1'b1;
    repeat (7) @(negedge clk); retire_i = 1'b0;
    rd(12'hB02, d); check("R3 ret count", d, 32'd7);
    rd(12'hC02, d); check("R9 ret alias", d, 32'd7);
    wr(12'h320, 32'd5);
    @(negedge clk); retire_i = 1'b1;
    repeat (3) @(negedge clk); retire_i = 1'b0;
    rd(12'hB02, d); check("R3 ret inhibited", d, 32'd7);
    wr(12'hB82, 32'h12);
    wr(12'hB02, 32'hFFFF_FFFF);
    wr(12'h320, 32'd1);
    @(negedge clk); retire_i = 1'b1;
    @(negedge clk); retire_i = 1'b0;
    rd(12'hB02, d); check("R3 ret wrap lo", d, 32'd0);
    rd(12'hB82, d); check("R3 ret carry hi", d, 32'h13);
    rd(12'hC82, d); check("R9 ret hi alias", d, 32'h13);

    // R6 sweep, all selectors enabled
    for (int k = 0; k < NE; k++) exp_cnt[k] = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      evt_i = pat(c, 3);
      for (int k = 0; k < NE; k++) if (evt_i[k]) exp_cnt[k]++;
    end
    @(negedge clk); evt_i = '0;
    for (int k = 0; k < NE; k++) begin
      rd(12'hB03 + 12'(k), d); check("R6 event sweep", d, 32'(exp_cnt[k]));
    end

    // R7 selectors, R5 per-counter inhibit
    for (int k = 0; k < NE; k++)
      wr(12'h323 + 12'(k), (k % 2 == 1) ? 32'd0 : 32'hFFFF_FFFF);
    for (int k = 0; k < NE; k++) begin
      rd(12'h323 + 12'(k), d);
      check("R7 selector readback", d, (k % 2 == 1) ? 32'd0 : (32'd1 << (k + 3)));
    end
    wr(12'h320, 32'h0000_0211);
    rd(12'h320, d); check("R5 inhibit bits", d, 32'h0000_0211);
    for (int k = 0; k < NE; k++) en[k] = (k % 2 == 0) && (k + 3 != 4) && (k + 3 != 9);
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      evt_i = pat(c, 11);
      for (int k = 0; k < NE; k++) if (evt_i[k] && en[k]) exp_cnt[k]++;
    end
    @(negedge clk); evt_i = '0;
    for (int k = 0; k < NE; k++) begin
      rd(12'hB03 + 12'(k), d); check("R7 gated sweep", d, 32'(exp_cnt[k]));
    end

    // R6 wrap on counter 7
    wr(12'hB07, 32'hFFFF_FFFF);
    @(negedge clk); evt_i = 10'b00_0001_0000;
    @(negedge clk); evt_i = '0;
    rd(12'hB07, d); check("R6 event wrap", d, 32'd0);

    // R8 high halves
    wr(12'hB85, 32'h55);
    rd(12'hB85, d); check("R8 hi zero", d, 32'd0);
    rd(12'hB05, d); check("R8 lo untouched", d, 32'(exp_cnt[2]));

    // R9 alias writes ignored (cycle inhibited)
    rd(12'hB00, a);
    wr(12'hC00, 32'h1234);
    rd(12'hB00, d);  check("R9 cyc alias write ignored", d, a);
    rd(12'hC00, d2); check("R9 cyc alias read", d2, a);
    wr(12'hC82, 32'h77);
    rd(12'hB82, d); check("R9 ret alias write ignored", d, 32'h13);

    // R11 unmapped
    rd(12'h7C0, d); check("R11 unmapped 7C0", d, 32'd0);
    rd(12'h321, d); check("R11 unmapped 321", d, 32'd0);
    rd(12'hB01, d); check("R11 unmapped B01", d, 32'd0);
    rd(12'hB8D, d); check("R11 unmapped B8D", d, 32'd0);
    rd(12'h32D, d); check("R11 unmapped 32D", d, 32'd0);

    // R10 instance without event counters
    rd1(12'hB03, d); check("R10 no event counter", d, 32'd0);
    rd1(12'hB07, d); check("R10 no event counter 7", d, 32'd0);
    rd1(12'h323, d); check("R10 no selector", d, 32'd0);
    rd1(12'h320, d); check("R10 inhibit", d, 32'd1);
    rd1(12'hB82, d); check("R10 ret hi still served", d, 32'h13);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule